// File: doc/BRIEF.md
# BAR Size Probe Sequencer

This block acts as a configuration master on the host side. It works out the type and the decoded size of every base address register of one function. After a start pulse it steps through the register slots one at a time, beginning at slot 0. For each slot it makes four accesses on a simple request/done configuration port:

- it reads the current contents,
- it writes all ones,
- it reads back what the hardware kept,
- it writes the original contents back.

A memory slot whose type field selects 64-bit decoding uses the following slot as its upper half. That slot gets the same four-access treatment and is not reported on its own.

From the saved original values and the read-back values, the block forms a 64-bit masked value. It isolates the lowest writable address bit and reports the span as a size-minus-one mask, for example 0x03FFFFFF for a 64 MB window. Each reported slot produces a one-cycle strobe carrying these fields:

- the slot index,
- a valid flag,
- the original attribute nibble,
- a 64-bit flag,
- the size mask.

A level completion flag rises once the last slot is handled.

Top module: `bar_probe_seq`

## Requirements
- R1: After `start`, slots are probed in strictly increasing index from 0 to NUM_BARS-1. Each slot, including a consumed upper half, gets exactly four accesses in this order: a read, a write of 0xFFFFFFFF, a read, and a write of the value returned by the first read. No access starts before the previous one has received `cfg_done`.
- R2: Only one access is outstanding at a time. `cfg_req` stays high until `cfg_done` is seen, and `cfg_idx`, `cfg_we` and `cfg_wdata` hold steady throughout.
- R3: A slot whose size read-back is zero is reported with `res_valid`=0 and `res_size`=0.
- R4: A lower-half size read-back of exactly 0xFFFFFFFF is taken as zero. The slot is then reported with `res_valid`=0 and `res_size`=0.
- R5: For a memory slot (original bit 0 = 0), bits 3:0 of the base and of the read-back are ignored. `res_size` = (v AND NOT(v-1)) - 1, where v is the masked read-back. So a read-back of 0xFFF00000 gives 0x000FFFFF, and `res_size`+1 is always zero or a power of two.
- R6: For an I/O slot (original bit 0 = 1), only bits 1:0 are ignored and the slot is never paired. A read-back of 0xFFFFFF01 gives 0xFF, and 0xFFFFFFFD gives 0x3.
- R7: A memory slot whose original bits 2:1 equal 2'b10 takes the next slot as bits 63:32, and the upper mask is all ones. The upper slot produces no strobe and `res_is64`=1. For example, a lower read-back of 0xFC00000C with an upper read-back of 0xFFFFFFFF or 0xFFFFFF0F gives 0x03FFFFFF, and a lower of 0x00000004 with an upper of 0xFFFFFFF0 gives 0xF_FFFFFFFF.
- R8: If the masked base equals the masked read-back and (base OR size) does not cover the whole mask, the size is 0 and the slot is invalid. For example, 0xF0F00000 in both gives 0, while 0xFFFFE000 in both gives 0x1FFF.
- R9: Each reported slot gives exactly one single-cycle `res_strobe`. `res_idx` is the lower slot index, `res_type` is bits 3:0 of the original value, and `res_valid` is 1 exactly when `res_size` is non-zero.
- R10: `all_done` rises after the last slot is reported and stays high until the next accepted `start`, which clears it one cycle later. `start` has no effect while a probe is running, and `cfg_req` is low whenever `all_done` is high.
- R11: A 64-bit type at the last slot is not paired. It is sized as a 32-bit memory slot with `res_is64`=0.
- R12: After reset, `cfg_req`, `res_strobe` and `all_done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a probe pass (taken only when idle) |
| cfg_req | output | 1 | Configuration access request, held until done |
| cfg_we | output | 1 | 1 = write, 0 = read |
| cfg_idx | output | IDX_W | Slot index of the access |
| cfg_wdata | output | 32 | Write data |
| cfg_done | input | 1 | Access completion, one cycle |
| cfg_rdata | input | 32 | Read data, valid with cfg_done |
| res_strobe | output | 1 | One-cycle result strobe |
| res_idx | output | IDX_W | Reported slot index |
| res_valid | output | 1 | Slot decodes a non-empty window |
| res_type | output | 4 | Original attribute nibble |
| res_is64 | output | 1 | Slot paired with the next as upper half |
| res_size | output | 64 | Size minus one |
| all_done | output | 1 | Pass complete |

## Verification
The bench runs three register images through a responder model with varying completion latency. The first image mixes 64-bit pairs, one with a clean upper read-back and one with stray low upper bits, together with an unused slot and an I/O slot. This separates correct pairing and upper masking from 32-bit handling. The second image covers a broken all-ones slot, an I/O slot whose bits mimic the 64-bit code, the base-equals-read-back hole case, and an upper-only window. These tell apart the zeroing rules, the I/O low-bit mask and a wrong lowest-bit search. The third image puts the equal-base case on its covering side and places a 64-bit type on the last slot, to expose pairing past the end. Directed tests add a start pulse in mid-run and a restart from the done state.

// File: rtl/bar_probe_pkg.sv
package bar_probe_pkg;

    localparam int WORD_W = 32;
    localparam int SPAN_W = 64;
    localparam logic [WORD_W-1:0] ALL_ONES = '1;

    // Top-level phase of a probe pass
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ACCESS = 2'd1,
        PH_CALC   = 2'd2
    } phase_e;

    // Access step within one dword probe (bit 0 doubles as write enable)
    typedef enum logic [1:0] {
        AC_RD_ORIG = 2'd0,
        AC_WR_ONES = 2'd1,
        AC_RD_SIZE = 2'd2,
        AC_WR_BACK = 2'd3
    } step_e;

    typedef struct packed {
        logic              valid;
        logic [3:0]        attr;
        logic              wide;
        logic [SPAN_W-1:0] span;
    } bar_report_t;

    // Low address bits that carry attributes rather than address
    function automatic logic [WORD_W-1:0] addr_keep(input logic is_io);
        return is_io ? ~WORD_W'(32'h3) : ~WORD_W'(32'hF);
    endfunction

    // Size-minus-one from base, read-back and significance mask
    function automatic logic [SPAN_W-1:0] span_of(
        input logic [SPAN_W-1:0] base,
        input logic [SPAN_W-1:0] maxb,
        input logic [SPAN_W-1:0] mask
    );
        logic [SPAN_W-1:0] v;
        logic [SPAN_W-1:0] s;
        v = maxb & mask;
        if (v == '0) begin
            s = '0;
        end else begin
            s = (v & ~(v - SPAN_W'(1))) - SPAN_W'(1);
            if ((base == maxb) && (((base | s) & mask) != mask))
                s = '0;
        end
        return s;
    endfunction

endpackage

// File: rtl/bar_cfg_port.sv
module bar_cfg_port
    import bar_probe_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              go_we,
    input  logic [IDX_W-1:0]  go_idx,
    input  logic [WORD_W-1:0] go_wdata,
    output logic              cfg_req,
    output logic              cfg_we,
    output logic [IDX_W-1:0]  cfg_idx,
    output logic [WORD_W-1:0] cfg_wdata,
    input  logic              cfg_done,
    input  logic [WORD_W-1:0] cfg_rdata,
    output logic              acc_done,
    output logic [WORD_W-1:0] acc_rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_req   <= 1'b0;
            cfg_we    <= 1'b0;
            cfg_idx   <= '0;
            cfg_wdata <= '0;
            acc_done  <= 1'b0;
            acc_rdata <= '0;
        end else begin
            acc_done <= 1'b0;
            if (!cfg_req && go) begin
                cfg_req   <= 1'b1;
                cfg_we    <= go_we;
                cfg_idx   <= go_idx;
                cfg_wdata <= go_wdata;
            end else if (cfg_req && cfg_done) begin
                cfg_req   <= 1'b0;
                acc_done  <= 1'b1;
                acc_rdata <= cfg_rdata;
            end
        end
    end

    // R2: request and its fields hold until completion
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && !cfg_done) |=> (cfg_req && $stable(cfg_idx) && $stable(cfg_we) && $stable(cfg_wdata)));

    // R2: a new access is never launched while one is outstanding
    assert_single_outstanding_R2: assert property (@(posedge clk) disable iff (rst)
        go |-> !cfg_req);

    // R1: completion is followed by a dropped request
    assert_done_drops_req_R1: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && cfg_done) |=> !cfg_req);

endmodule

// File: rtl/bar_size_calc.sv
module bar_size_calc
    import bar_probe_pkg::*;
(
    input  logic [WORD_W-1:0] lo_orig,
    input  logic [WORD_W-1:0] lo_rb,
    input  logic [WORD_W-1:0] hi_orig,
    input  logic [WORD_W-1:0] hi_rb,
    input  logic              wide,
    output bar_report_t       rpt
);

    logic [WORD_W-1:0] keep;
    logic [WORD_W-1:0] lo_rb_eff;
    logic [SPAN_W-1:0] base64;
    logic [SPAN_W-1:0] maxb64;
    logic [SPAN_W-1:0] mask64;
    logic [SPAN_W-1:0] span;

    always_comb begin
        keep      = addr_keep(lo_orig[0]);
        lo_rb_eff = (lo_rb == ALL_ONES) ? '0 : lo_rb;
        base64    = {wide ? hi_orig  : '0, lo_orig   & keep};
        maxb64    = {wide ? hi_rb    : '0, lo_rb_eff & keep};
        mask64    = {wide ? ALL_ONES : '0, keep};
        span      = span_of(base64, maxb64, mask64);
        rpt.valid = (span != '0);
        rpt.attr  = lo_orig[3:0];
        rpt.wide  = wide;
        rpt.span  = span;
    end

endmodule

// File: rtl/bar_probe_seq.sv
module bar_probe_seq
    import bar_probe_pkg::*;
#(
    parameter int NUM_BARS = 6,
    parameter int IDX_W    = $clog2(NUM_BARS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              cfg_req,
    output logic              cfg_we,
    output logic [IDX_W-1:0]  cfg_idx,
    output logic [31:0]       cfg_wdata,
    input  logic              cfg_done,
    input  logic [31:0]       cfg_rdata,
    output logic              res_strobe,
    output logic [IDX_W-1:0]  res_idx,
    output logic              res_valid,
    output logic [3:0]        res_type,
    output logic              res_is64,
    output logic [63:0]       res_size,
    output logic              all_done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BARS - 1);

    phase_e            phase;
    step_e             step;
    logic              pend;
    logic              upper;
    logic              wide;
    logic [IDX_W-1:0]  cur_idx;
    logic [IDX_W-1:0]  rep_idx;
    logic [WORD_W-1:0] lo_orig, lo_rb, hi_orig, hi_rb;

    logic              go;
    logic              go_we;
    logic [WORD_W-1:0] go_wdata;
    logic              acc_done;
    logic [WORD_W-1:0] acc_rdata;
    logic              pair_ok;
    bar_report_t       rpt;

    always_comb begin
        go       = (phase == PH_ACCESS) && !pend;
        go_we    = step[0];
        go_wdata = (step == AC_WR_ONES) ? ALL_ONES : (upper ? hi_orig : lo_orig);
        pair_ok  = !lo_orig[0] && (lo_orig[2:1] == 2'b10) && (cur_idx != LAST_IDX);
    end

    bar_cfg_port #(.IDX_W(IDX_W)) u_port (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .go_we     (go_we),
        .go_idx    (cur_idx),
        .go_wdata  (go_wdata),
        .cfg_req   (cfg_req),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_done  (cfg_done),
        .cfg_rdata (cfg_rdata),
        .acc_done  (acc_done),
        .acc_rdata (acc_rdata)
    );

    bar_size_calc u_calc (
        .lo_orig (lo_orig),
        .lo_rb   (lo_rb),
        .hi_orig (hi_orig),
        .hi_rb   (hi_rb),
        .wide    (wide),
        .rpt     (rpt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            step       <= AC_RD_ORIG;
            pend       <= 1'b0;
            upper      <= 1'b0;
            wide       <= 1'b0;
            cur_idx    <= '0;
            rep_idx    <= '0;
            lo_orig    <= '0;
            lo_rb      <= '0;
            hi_orig    <= '0;
            hi_rb      <= '0;
            res_strobe <= 1'b0;
            res_idx    <= '0;
            res_valid  <= 1'b0;
            res_type   <= '0;
            res_is64   <= 1'b0;
            res_size   <= '0;
            all_done   <= 1'b0;
        end else begin
            res_strobe <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase    <= PH_ACCESS;
                        step     <= AC_RD_ORIG;
                        pend     <= 1'b0;
                        upper    <= 1'b0;
                        wide     <= 1'b0;
                        cur_idx  <= '0;
                        rep_idx  <= '0;
                        hi_orig  <= '0;
                        hi_rb    <= '0;
                        all_done <= 1'b0;
                    end
                end
                PH_ACCESS: begin
                    if (acc_done) begin
                        pend <= 1'b0;
                        if (step == AC_RD_ORIG) begin
                            if (upper) hi_orig <= acc_rdata;
                            else       lo_orig <= acc_rdata;
                        end
                        if (step == AC_RD_SIZE) begin
                            if (upper) hi_rb <= acc_rdata;
                            else       lo_rb <= acc_rdata;
                        end
                        if (step == AC_WR_BACK) begin
                            step <= AC_RD_ORIG;
                            if (!upper && pair_ok) begin
                                upper   <= 1'b1;
                                wide    <= 1'b1;
                                cur_idx <= cur_idx + IDX_W'(1);
                            end else begin
                                phase <= PH_CALC;
                            end
                        end else begin
                            step <= step_e'(step + 2'd1);
                        end
                    end else if (!pend) begin
                        pend <= 1'b1;
                    end
                end
                PH_CALC: begin
                    res_strobe <= 1'b1;
                    res_idx    <= rep_idx;
                    res_valid  <= rpt.valid;
                    res_type   <= rpt.attr;
                    res_is64   <= rpt.wide;
                    res_size   <= rpt.span;
                    if (cur_idx == LAST_IDX) begin
                        phase    <= PH_IDLE;
                        all_done <= 1'b1;
                    end else begin
                        phase   <= PH_ACCESS;
                        step    <= AC_RD_ORIG;
                        pend    <= 1'b0;
                        upper   <= 1'b0;
                        wide    <= 1'b0;
                        hi_orig <= '0;
                        hi_rb   <= '0;
                        cur_idx <= cur_idx + IDX_W'(1);
                        rep_idx <= cur_idx + IDX_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R5: reported size plus one is a power of two (or the full 64-bit wrap)
    assert_span_pow2_R5: assert property (@(posedge clk) disable iff (rst)
        res_strobe |-> $onehot0(res_size + 64'd1));

    // R6: an I/O slot is never reported as paired
    assert_io_unpaired_R6: assert property (@(posedge clk) disable iff (rst)
        (res_strobe && res_type[0]) |-> !res_is64);

    // R11: pairing never reaches past the final slot
    assert_no_pair_at_end_R11: assert property (@(posedge clk) disable iff (rst)
        (res_strobe && res_is64) |-> (res_idx != LAST_IDX));

    // R9: result strobe is a single-cycle pulse
    assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        res_strobe |=> !res_strobe);

    // R10: no configuration traffic once the pass is complete
    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        all_done |-> !cfg_req);

    // R3: an invalid report carries a zero size
    assert_invalid_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (res_strobe && !res_valid) |-> (res_size == 64'd0));

endmodule

// File: tb/bar_probe_seq_test.sv
module bar_probe_seq_test;

    localparam int NB  = 6;
    localparam int IW  = 3;
    localparam int NSC = 3;

    // Register images: original contents and value kept after the all-ones write
    localparam logic [31:0] IMG_ORIG [NSC][NB] = '{
        '{32'h0000000C, 32'h0, 32'h0000000C, 32'h0, 32'h0, 32'h00000001},
        '{32'h0, 32'h0, 32'h00000005, 32'hF0F00000, 32'h00000004, 32'h0},
        '{32'hFFFFE000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h00000004}
    };
    localparam logic [31:0] IMG_RB [NSC][NB] = '{
        '{32'hFC00000C, 32'hFFFFFFFF, 32'hFC00000C, 32'hFFFFFF0F, 32'h0, 32'hFFFFFF01},
        '{32'hFFF00000, 32'hFFFFFFFF, 32'hFFFFFFFD, 32'hF0F00000, 32'h00000004, 32'hFFFFFFF0},
        '{32'hFFFFE000, 32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFF0004}
    };
    localparam logic EXP_STB [NSC][NB] = '{
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}
    };
    localparam logic EXP_VLD [NSC][NB] = '{
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}
    };
    localparam logic EXP_W64 [NSC][NB] = '{
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
    };
    localparam logic [3:0] EXP_TYP [NSC][NB] = '{
        '{4'hC, 4'h0, 4'hC, 4'h0, 4'h0, 4'h1},
        '{4'h0, 4'h0, 4'h5, 4'h0, 4'h4, 4'h0},
        '{4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h4}
    };
    localparam logic [63:0] EXP_SZ [NSC][NB] = '{
        '{64'h3FFFFFF, 64'h0, 64'h3FFFFFF, 64'h0, 64'h0, 64'hFF},
        '{64'hFFFFF, 64'h0, 64'h3, 64'h0, 64'hF_FFFFFFFF, 64'h0},
        '{64'h1FFF, 64'h0, 64'h0, 64'h0, 64'h0, 64'hFFFF}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          cfg_req, cfg_we;
    logic [IW-1:0] cfg_idx;
    logic [31:0]   cfg_wdata;
    logic          cfg_done = 1'b0;
    logic [31:0]   cfg_rdata = '0;
    logic          res_strobe, res_valid, res_is64, all_done;
    logic [IW-1:0] res_idx;
    logic [3:0]    res_type;
    logic [63:0]   res_size;

    always #5 clk = ~clk;

    bar_probe_seq #(.NUM_BARS(NB)) uut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_done(cfg_done), .cfg_rdata(cfg_rdata),
        .res_strobe(res_strobe), .res_idx(res_idx), .res_valid(res_valid),
        .res_type(res_type), .res_is64(res_is64), .res_size(res_size), .all_done(all_done)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Responder model state
    logic [31:0] mdl_val  [NB];
    logic [31:0] mdl_rb   [NB];
    bit          mdl_ones [NB];
    int exp_idx = 0, exp_step = 0, proto_err = 0, stab_err = 0;
    int wait_cnt = 0, lat = 0, acc_n = 0;
    logic          prev_req = 1'b0, prev_done = 1'b0, prev_we = 1'b0;
    logic [IW-1:0] prev_idx = '0;
    logic [31:0]   prev_wdata = '0;

    initial begin
        forever begin
            @(negedge clk);
            if (!rst && cfg_req && prev_req && !prev_done &&
                (cfg_idx != prev_idx || cfg_we != prev_we || cfg_wdata != prev_wdata))
                stab_err++;
            prev_req = cfg_req; prev_idx = cfg_idx; prev_we = cfg_we; prev_wdata = cfg_wdata;
            if (cfg_done) begin
                cfg_done = 1'b0;
            end else if (!rst && cfg_req) begin
                if (wait_cnt < lat) begin
                    wait_cnt++;
                end else begin
                    if (int'(cfg_idx) != exp_idx) proto_err++;
                    case (exp_step)
                        0, 2: if (cfg_we) proto_err++;
                        1: if (!cfg_we || cfg_wdata != 32'hFFFFFFFF) proto_err++;
                        default: if (!cfg_we || cfg_wdata != mdl_val[cfg_idx]) proto_err++;
                    endcase
                    if (cfg_we) begin
                        if (cfg_wdata == 32'hFFFFFFFF) mdl_ones[cfg_idx] = 1'b1;
                        else begin mdl_val[cfg_idx] = cfg_wdata; mdl_ones[cfg_idx] = 1'b0; end
                    end else begin
                        cfg_rdata = mdl_ones[cfg_idx] ? mdl_rb[cfg_idx] : mdl_val[cfg_idx];
                    end
                    if (exp_step == 3) begin exp_step = 0; exp_idx++; end
                    else exp_step++;
                    cfg_done = 1'b1;
                    wait_cnt = 0;
                    acc_n++;
                    lat = acc_n % 3;
                end
            end
            prev_done = cfg_done;
        end
    end

    // Result monitor
    int          got_cnt [NB];
    logic        got_vld [NB];
    logic        got_w64 [NB];
    logic [3:0]  got_typ [NB];
    logic [63:0] got_sz  [NB];

    always @(negedge clk) begin
        if (!rst && res_strobe) begin
            got_cnt[res_idx] <= got_cnt[res_idx] + 1;
            got_vld[res_idx] <= res_valid;
            got_w64[res_idx] <= res_is64;
            got_typ[res_idx] <= res_type;
            got_sz[res_idx]  <= res_size;
        end
    end

    task automatic load_image(input int s);
        for (int i = 0; i < NB; i++) begin
            mdl_val[i] = IMG_ORIG[s][i];
            mdl_rb[i]  = IMG_RB[s][i];
            mdl_ones[i] = 1'b0;
            got_cnt[i] = 0;
        end
        exp_idx = 0; exp_step = 0; proto_err = 0; stab_err = 0;
    endtask

    task automatic wait_done(input int limit);
        int n = 0;
        while (!all_done && n < limit) begin @(negedge clk); n++; end
        check(all_done, "R10 all_done rises after pass", 64'(all_done), 64'd1);
        @(negedge clk);
    endtask

    task automatic verify_image(input int s);
        for (int i = 0; i < NB; i++) begin
            check(got_cnt[i] == (EXP_STB[s][i] ? 1 : 0), $sformatf("R9/R7 strobe count sc%0d slot%0d", s, i),
                  64'(got_cnt[i]), 64'(EXP_STB[s][i]));
            if (EXP_STB[s][i]) begin
                check(got_sz[i] == EXP_SZ[s][i], $sformatf("R5 R6 R7 R8 size sc%0d slot%0d", s, i),
                      got_sz[i], EXP_SZ[s][i]);
                check(got_vld[i] == EXP_VLD[s][i], $sformatf("R3 R4 R9 valid sc%0d slot%0d", s, i),
                      64'(got_vld[i]), 64'(EXP_VLD[s][i]));
                check(got_w64[i] == EXP_W64[s][i], $sformatf("R7 R11 is64 sc%0d slot%0d", s, i),
                      64'(got_w64[i]), 64'(EXP_W64[s][i]));
                check(got_typ[i] == EXP_TYP[s][i], $sformatf("R9 type sc%0d slot%0d", s, i),
                      64'(got_typ[i]), 64'(EXP_TYP[s][i]));
            end
            check(mdl_val[i] == IMG_ORIG[s][i], $sformatf("R1 restore sc%0d slot%0d", s, i),
                  64'(mdl_val[i]), 64'(IMG_ORIG[s][i]));
        end
        check(proto_err == 0, $sformatf("R1 access order sc%0d", s), 64'(proto_err), 64'd0);
        check(exp_idx == NB && exp_step == 0, $sformatf("R1 slots probed sc%0d", s), 64'(exp_idx), 64'(NB));
        check(stab_err == 0, $sformatf("R2 request stable sc%0d", s), 64'(stab_err), 64'd0);
        check(!cfg_req, "R10 quiet when done", 64'(cfg_req), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < NB; i++) begin
            mdl_val[i] = '0; mdl_rb[i] = '0; mdl_ones[i] = 1'b0;
            got_cnt[i] = 0; got_vld[i] = 1'b0; got_w64[i] = 1'b0; got_typ[i] = '0; got_sz[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        check(!cfg_req, "R12 cfg_req after reset", 64'(cfg_req), 64'd0);
        check(!res_strobe, "R12 res_strobe after reset", 64'(res_strobe), 64'd0);
        check(!all_done, "R12 all_done after reset", 64'(all_done), 64'd0);

        // Table-driven passes
        for (int s = 0; s < NSC; s++) begin
            load_image(s);
            start = 1'b1; @(negedge clk); start = 1'b0;
            wait_done(5000);
            verify_image(s);
        end

        // R10: all_done holds, restart clears it, start ignored mid-pass
        repeat (5) @(negedge clk);
        check(all_done, "R10 all_done holds", 64'(all_done), 64'd1);
        load_image(0);
        start = 1'b1; @(negedge clk); start = 1'b0;
        check(!all_done, "R10 all_done cleared by start", 64'(all_done), 64'd0);
        repeat (25) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_done(5000);
        verify_image(0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=complete");
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule